// File: doc/BRIEF.md
# Graphics Interrupt Status Collector

This block gathers the interrupt events of a graphics engine into sticky status bits and drives one shared, level-sensitive, active-low interrupt line. There are four event inputs, one per source: blit completion, vertical sync arriving at the output stage, output-stage underflow, and capture of the final line. Each source signals with a single-cycle pulse. A status bit stays set until software clears it.

Software reaches the block through a small register port. The port has a read-only status view and a write-only clear register; writing a 1 to a clear bit removes the matching status bit. It also has an enable mask that decides which status bits can pull the line low, and a read-only field that names the most urgent pending source. Because several sources share the line, a handler reads the status or priority view again and again. It clears one source per pass, in priority order, until the line returns high.

Top module: `gfx_irq_collector`

## Requirements
- R1: A one-cycle high pulse on `evt_i[k]` sets status bit k on the next clock edge. Bit 0 is blit done, bit 1 is vertical sync, bit 2 is underflow and bit 3 is last line. Status is read at register address 0, in bits [3:0].
- R2: A status bit stays set, with no further events, until it is cleared through the clear register.
- R3: A write to address 1 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R4: When an event pulse and a clear of the same bit fall on the same edge, the bit ends up set.
- R5: `irq_n_o` is low whenever at least one enabled status bit is set. It returns high only after all enabled set bits have been cleared.
- R6: The enable mask sits at address 2, bits [3:0], with 1 meaning enabled. A masked source still sets its status bit but cannot pull `irq_n_o` low. Enabling a source whose status bit is already set asserts the line.
- R7: Address 3 returns the index of the lowest-numbered set status bit in bits [1:0], and a pending flag in bit 7. When no status bit is set, the whole word reads zero.
- R8: A read of address 1 returns zero. A read of address 2 returns the mask last written.
- R9: While `rst_n` is low at a clock edge, all status bits are cleared, the mask becomes all ones, and `irq_n_o` goes high.
- R10: A write to address 0 or address 3 changes neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational from address) |
| irq_n_o | output | 1 | Shared interrupt line, active low |

## Verification
The bench builds the block with NUM_SRC = 4 and DATA_W = 32. With four sources, every single-bit and multi-bit status pattern can be reached in a short vector walk. This includes a set and a clear landing on the same edge, and masked sources that hold status while the line stays high. With a 32-bit data word, the pending flag at bit 7 and the unused upper write bits are both in reach, so the bench can confirm that writes to the read-only addresses leave everything unchanged.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;

    // Register selector; the address value is the register's location
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CLEAR  = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_PRIO   = 2'd3
    } reg_sel_e;

    // Bit of the priority word that flags "something pending"
    localparam int PRIO_ANY_BIT = 7;

endpackage

// File: rtl/gfx_irq_prio_enc.sv
module gfx_irq_prio_enc #(
    parameter int NUM_SRC = 4,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);

    // Scan from the top down so the lowest set index is written last
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/gfx_irq_state.sv
module gfx_irq_state #(
    parameter int                 NUM_SRC  = 4,
    parameter logic [NUM_SRC-1:0] MASK_RST = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic [NUM_SRC-1:0] mask_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Clear first, then set: a pulse on the clearing edge survives
        state_d.status = (state_q.status & ~clr_i) | evt_i;
        if (mask_wr_i) begin
            state_d.mask = mask_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.status <= '0;
            state_q.mask   <= MASK_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;
    assign mask_o   = state_q.mask;

endmodule

// File: rtl/gfx_irq_regif.sv
module gfx_irq_regif
    import gfx_irq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [1:0]         addr_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [IDX_W-1:0]   prio_idx_i,
    input  logic               prio_any_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic               mask_wr_o,
    output logic [NUM_SRC-1:0] mask_wdata_o,
    output logic [DATA_W-1:0]  rdata_o
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr_i);

    generate
        if (DATA_W > NUM_SRC) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];
        end
    endgenerate

    // Write decode: only the clear and mask locations accept data
    always_comb begin
        clr_o        = '0;
        mask_wr_o    = 1'b0;
        mask_wdata_o = wdata_i[NUM_SRC-1:0];
        if (wr_i) begin
            case (sel)
                SEL_CLEAR: clr_o     = wdata_i[NUM_SRC-1:0];
                SEL_MASK:  mask_wr_o = 1'b1;
                default:   ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_STATUS: rdata_o[NUM_SRC-1:0] = status_i;
            SEL_MASK:   rdata_o[NUM_SRC-1:0] = mask_i;
            SEL_PRIO: begin
                rdata_o[IDX_W-1:0]    = prio_idx_i;
                rdata_o[PRIO_ANY_BIT] = prio_any_i;
            end
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/gfx_irq_collector.sv
module gfx_irq_collector #(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [1:0]         reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_n_o
);

    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] clr;
    logic               mask_wr;
    logic [NUM_SRC-1:0] mask_wdata;
    logic [IDX_W-1:0]   prio_idx;
    logic               prio_any;

    gfx_irq_state #(
        .NUM_SRC  (NUM_SRC),
        .MASK_RST ({NUM_SRC{1'b1}})
    ) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .clr_i        (clr),
        .mask_wr_i    (mask_wr),
        .mask_wdata_i (mask_wdata),
        .status_o     (status_q),
        .mask_o       (mask_q)
    );

    gfx_irq_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_prio (
        .req_i (status_q),
        .idx_o (prio_idx),
        .any_o (prio_any)
    );

    gfx_irq_regif #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_regif (
        .addr_i       (reg_addr_i),
        .wr_i         (reg_wr_i),
        .wdata_i      (reg_wdata_i),
        .status_i     (status_q),
        .mask_i       (mask_q),
        .prio_idx_i   (prio_idx),
        .prio_any_i   (prio_any),
        .clr_o        (clr),
        .mask_wr_o    (mask_wr),
        .mask_wdata_o (mask_wdata),
        .rdata_o      (reg_rdata_o)
    );

    // Shared line, active low, driven from registered state only
    assign irq_n_o = ~|(status_q & mask_q);

endmodule

// File: rtl/gfx_irq_collector_chk.sv
module gfx_irq_collector_chk
    import gfx_irq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic [1:0]         reg_addr_i,
    input logic               reg_wr_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic [DATA_W-1:0]  reg_rdata_o,
    input logic               irq_n_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q
);

    logic unused_chk;
    assign unused_chk = ^{reg_wdata_i, reg_rdata_o, mask_q};

    logic clr_wr;
    assign clr_wr = reg_wr_i && (reg_addr_i == SEL_CLEAR);

    genvar k;
    generate
        for (k = 0; k < NUM_SRC; k++) begin : g_bit
            // R1 and R4: a pulse always leaves the bit set
            assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[k] |=> status_q[k]);
            // R2: stickiness without a clear
            assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[k] && !(clr_wr && reg_wdata_i[k])) |=> status_q[k]);
            // R3: a clear without a competing pulse empties the bit
            assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_wr && reg_wdata_i[k] && !evt_i[k]) |=> !status_q[k]);
        end
    endgenerate

    // R5: a low line implies pending status
    assert_line_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (status_q != '0));

    // R5: the line is released only through a register write
    assert_release_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n_o) |-> $past(reg_wr_i));

    // R7: the highest-ranked source wins the priority field
    assert_prio_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr_i == SEL_PRIO) && status_q[0]) |-> (reg_rdata_o[1:0] == 2'd0));

    // R9: reset clears state and releases the line
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> ((status_q == '0) && irq_n_o));

endmodule

bind gfx_irq_collector gfx_irq_collector_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (.*);

// File: tb/gfx_irq_collector_tb.sv
`timescale 1ns/1ps
module gfx_irq_collector_tb;

    localparam int NUM_SRC = 4;
    localparam int DATA_W  = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] evt_i = '0;
    logic [1:0]         reg_addr_i = '0;
    logic               reg_wr_i = 1'b0;
    logic [DATA_W-1:0]  reg_wdata_i = '0;
    logic [DATA_W-1:0]  reg_rdata_o;
    logic               irq_n_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gfx_irq_collector #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr_i(reg_addr_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
    );

    // {evt[4], wr, addr[2], wdata[4], exp_status[4], exp_irq_n}
    localparam int NVEC = 15;
    localparam logic [15:0] VEC [NVEC] = '{
        {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b0}, // R1 blit done
        {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b0}, // R2 sticky
        {4'b0100, 1'b0, 2'd0, 4'b0000, 4'b0101, 1'b0}, // R1 underflow
        {4'b0000, 1'b1, 2'd1, 4'b0000, 4'b0101, 1'b0}, // R3 zero write
        {4'b0000, 1'b1, 2'd1, 4'b0001, 4'b0100, 1'b0}, // R3 clear bit0
        {4'b0100, 1'b1, 2'd1, 4'b0100, 4'b0100, 1'b0}, // R4 set wins
        {4'b0000, 1'b1, 2'd1, 4'b0100, 4'b0000, 1'b1}, // R5 release
        {4'b0000, 1'b1, 2'd0, 4'b1111, 4'b0000, 1'b1}, // R10 status ro
        {4'b0000, 1'b1, 2'd2, 4'b1110, 4'b0000, 1'b1}, // R6 mask bit0
        {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b1}, // R6 masked record
        {4'b1000, 1'b0, 2'd0, 4'b0000, 4'b1001, 1'b0}, // R1 last line
        {4'b0000, 1'b1, 2'd1, 4'b1000, 4'b0001, 1'b1}, // R5 masked left
        {4'b0000, 1'b1, 2'd2, 4'b1111, 4'b0001, 1'b0}, // R6 enable pending
        {4'b1110, 1'b0, 2'd0, 4'b0000, 4'b1111, 1'b0}, // R1 vsync etc
        {4'b0000, 1'b1, 2'd1, 4'b1111, 4'b0000, 1'b1}  // R3 clear all
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] evt, input logic wr,
                        input logic [1:0] addr, input logic [DATA_W-1:0] wdata);
        @(negedge clk);
        evt_i = evt; reg_wr_i = wr; reg_addr_i = addr; reg_wdata_i = wdata;
        @(posedge clk);
        #0.5;
        evt_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rd(input logic [1:0] addr, output logic [DATA_W-1:0] data);
        reg_addr_i = addr;
        #0.3;
        data = reg_rdata_o;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (3) @(posedge clk);
        #0.5;
        // R9 reset state
        rd(2'd0, d); check("R9 status", d, 32'h0);
        rd(2'd2, d); check("R9 mask", d, 32'hF);
        check("R9 irq_n", {31'b0, irq_n_o}, 32'h1);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][15:12], VEC[i][11], VEC[i][10:9], {28'b0, VEC[i][8:5]});
            rd(2'd0, d);
            check($sformatf("R1-table vec%0d status", i), d, {28'b0, VEC[i][4:1]});
            check($sformatf("R5 vec%0d irq_n", i), {31'b0, irq_n_o}, {31'b0, VEC[i][0]});
        end

        // R7 priority field
        step(4'b1100, 1'b0, 2'd0, '0);
        rd(2'd3, d); check("R7 idx2", d, 32'h82);
        step(4'b0000, 1'b1, 2'd1, 32'h4);
        rd(2'd3, d); check("R7 idx3", d, 32'h83);
        step(4'b0010, 1'b0, 2'd0, '0);
        rd(2'd3, d); check("R7 idx1", d, 32'h81);
        step(4'b0000, 1'b1, 2'd1, 32'hF);
        rd(2'd3, d); check("R7 none", d, 32'h0);

        // R8 readback
        step(4'b0000, 1'b1, 2'd2, 32'hFFFF_FFF5);
        rd(2'd2, d); check("R8 mask readback", d, 32'h5);
        rd(2'd1, d); check("R8 clear reads zero", d, 32'h0);

        // R10 write to priority address ignored
        step(4'b0001, 1'b0, 2'd0, '0);
        step(4'b0000, 1'b1, 2'd3, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R10 status kept", d, 32'h1);
        rd(2'd2, d); check("R10 mask kept", d, 32'h5);

        // R9 mid-run reset
        step(4'b1010, 1'b0, 2'd0, '0);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #0.5;
        rd(2'd0, d); check("R9 status cleared", d, 32'h0);
        rd(2'd2, d); check("R9 mask restored", d, 32'hF);
        check("R9 irq_n high", {31'b0, irq_n_o}, 32'h1);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        report();
    end

endmodule